// File: doc/BRIEF.md
# Linked-Descriptor Scatter-Gather Walker

This block sits in front of a data mover and turns a linked list of in-memory descriptors into a series of segment transfers. Software only places the address of the first descriptor on `head_addr` and pulses `start`. After that, the walker needs no further software action. It reads each descriptor through a single-outstanding 32-bit memory master port. It hands the segment's buffer address and byte count to the mover and waits for the mover to report completion. It then returns the descriptor to software by clearing its ownership bit in memory, and follows the next pointer. In this way, segments of different sizes at unrelated addresses move as one logical operation, in chain order.

Each descriptor occupies 24 bytes and is read as six little-endian 32-bit words. Word 0 is the low half of the buffer address and word 1 is the high half. Word 2 is the segment size in bytes. Word 3 is the control word. Word 4 is the low half of the next-descriptor address and word 5 is the high half. The control word has three defined bits. Bit 0 marks the last descriptor of the chain. Bit 1 requests an interrupt when the segment finishes. Bit 31 means the descriptor belongs to the walker.

The walker ends normally on the last-descriptor bit or on a null next pointer. It ends with an error on a descriptor it does not own. Two sticky status outputs report how the walk ended, and both are cleared by the next accepted start.

Top module: `sg_chain_walker`

## Requirements
- R1: An accepted `start` latches `head_addr`. The walker then reads the descriptor words at offsets +0, +4, +8, +12, +16 and +20 from that address, in that order, with word 0 in the low half of the 64-bit fields.
- R2: Each owned descriptor with a non-zero size produces exactly one single-cycle `mv_start`, with `mv_addr` equal to the 64-bit buffer address and `mv_len` equal to the size. Segments are issued in chain order, and the walker does not go on until `mv_done` arrives.
- R3: A descriptor whose size is zero never pulses `mv_start`. Its write-back and interrupt handling are the same as for any other descriptor.
- R4: After each owned descriptor's segment, the walker writes the control word back to descriptor address +12. The written word has bit 31 cleared and every other bit unchanged.
- R5: A fetched descriptor with control bit 31 clear stops the walk. It gets no mover start and no write-back. The walker sets `own_err` and pulses `irq` for one cycle.
- R6: Control bit 0 set ends the walk after that descriptor's write-back, whatever its next pointer holds, and sets `chain_done`.
- R7: A next pointer of zero ends the walk after that descriptor's write-back, and sets `chain_done`.
- R8: A descriptor with control bit 1 set produces a single-cycle `irq` pulse in the cycle after its write-back is acknowledged. A descriptor with bit 1 clear produces none.
- R9: `start` is ignored while `busy` is high. An accepted `start` clears `chain_done` and `own_err`.
- R10: Once raised, `mem_req` stays high until `mem_ack`, and `mem_addr` and `mem_we` stay unchanged over that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk at `head_addr` (ignored while busy) |
| head_addr | input | 64 | Address of the first descriptor |
| busy | output | 1 | Walk in progress |
| chain_done | output | 1 | Sticky: last walk ended normally |
| own_err | output | 1 | Sticky: last walk hit a descriptor it did not own |
| irq | output | 1 | Single-cycle interrupt pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mv_start | output | 1 | Start one segment on the data mover |
| mv_addr | output | 64 | Segment buffer address |
| mv_len | output | 32 | Segment length in bytes |
| mv_done | input | 1 | Data mover finished the segment |

## Verification
A wrong word index or a stale current-descriptor pointer shows up on `mem_addr` in the next read. It is visible within a cycle of the faulty acknowledge, and the read-address log compares it against the expected order. A mis-decoded control word shows up in three places. The first is a missing or extra `mv_start`, or wrong segment fields, at the end of the fetch. The second is a write-back word with the wrong bits. The third is a walk that follows one descriptor too many or stops early. All three appear as soon as that descriptor is processed. Interrupt and status mistakes show up as a wrong count of `irq` cycles per walk, or a wrong sticky bit, once `busy` falls.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int ADDR_W        = 64;
    localparam int WORD_W        = 32;
    localparam int DESC_WORDS    = 6;
    localparam int IDX_W         = $clog2(DESC_WORDS);
    localparam int CTRL_WORD_IDX = 3;
    localparam int CTRL_OFFSET   = CTRL_WORD_IDX * (WORD_W / 8);
    localparam int BIT_LAST      = 0;
    localparam int BIT_IRQ       = 1;
    localparam int BIT_OWN       = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_MOVE,
        ST_WAIT,
        ST_WBACK
    } walk_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] buf_addr;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] ctrl;
        logic [ADDR_W-1:0] next;
    } desc_t;

    typedef struct packed {
        walk_state_t       st;
        logic [ADDR_W-1:0] cur;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic              err;
        logic              irq;
    } walk_regs_t;
endpackage

// File: rtl/sgw_desc_regs.sv
module sgw_desc_regs #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 6,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [WORD_W-1:0]        wdata,
    output logic [NWORDS*WORD_W-1:0] flat
);
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [WORD_W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (we && idx == IDX_W'(g)) begin
                w_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= '0;
            end else begin
                w_q <= w_d;
            end
        end

        assign flat[g*WORD_W +: WORD_W] = w_q;
    end
endmodule

// File: rtl/sgw_ctrl_decode.sv
module sgw_ctrl_decode
    import sgw_pkg::*;
(
    input  desc_t desc,
    output logic  owned,
    output logic  want_irq,
    output logic  empty,
    output logic  tail,
    output logic  [WORD_W-1:0] ctrl_ret
);
    always_comb begin
        owned    = desc.ctrl[BIT_OWN];
        want_irq = desc.ctrl[BIT_IRQ];
        empty    = (desc.size == '0);
        // Either end condition closes the chain; the flag wins over a live pointer.
        tail     = desc.ctrl[BIT_LAST] || (desc.next == '0);
        ctrl_ret = desc.ctrl;
        ctrl_ret[BIT_OWN] = 1'b0;
    end
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       head_addr,
    output logic              busy,
    output logic              chain_done,
    output logic              own_err,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              mv_start,
    output logic [63:0]       mv_addr,
    output logic [31:0]       mv_len,
    input  logic              mv_done
);
    localparam int HALF = ADDR_W / WORD_W;

    walk_regs_t r_d, r_q;
    desc_t      desc;
    logic [DESC_WORDS*WORD_W-1:0] desc_flat;
    logic       cap_we;
    logic       d_owned, d_irq, d_empty, d_tail;
    logic [WORD_W-1:0] d_ctrl_ret;

    assign cap_we = (r_q.st == ST_FETCH) && mem_ack;

    sgw_desc_regs #(
        .WORD_W (WORD_W),
        .NWORDS (DESC_WORDS)
    ) u_desc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cap_we),
        .idx   (r_q.idx),
        .wdata (mem_rdata),
        .flat  (desc_flat)
    );

    // R1: little-endian assembly of the six captured words
    always_comb begin
        desc.buf_addr = desc_flat[0*WORD_W +: HALF*WORD_W];
        desc.size     = desc_flat[2*WORD_W +: WORD_W];
        desc.ctrl     = desc_flat[CTRL_WORD_IDX*WORD_W +: WORD_W];
        desc.next     = desc_flat[4*WORD_W +: HALF*WORD_W];
    end

    sgw_ctrl_decode u_dec (
        .desc     (desc),
        .owned    (d_owned),
        .want_irq (d_irq),
        .empty    (d_empty),
        .tail     (d_tail),
        .ctrl_ret (d_ctrl_ret)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.cur  = head_addr;
                    r_d.idx  = '0;
                    r_d.done = 1'b0;
                    r_d.err  = 1'b0;
                    r_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    if (r_q.idx == IDX_W'(DESC_WORDS - 1)) begin
                        r_d.st = ST_CHECK;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                if (!d_owned) begin
                    r_d.err = 1'b1;
                    r_d.irq = 1'b1;
                    r_d.st  = ST_IDLE;
                end else if (d_empty) begin
                    r_d.st = ST_WBACK;
                end else begin
                    r_d.st = ST_MOVE;
                end
            end
            ST_MOVE: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mv_done) begin
                    r_d.st = ST_WBACK;
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    r_d.irq = d_irq;
                    if (d_tail) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.cur = desc.next;
                        r_d.idx = '0;
                        r_d.st  = ST_FETCH;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cur: '0, idx: '0, done: 1'b0, err: 1'b0, irq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req   = (r_q.st == ST_FETCH) || (r_q.st == ST_WBACK);
        mem_we    = (r_q.st == ST_WBACK);
        mem_addr  = mem_we ? (r_q.cur + ADDR_W'(CTRL_OFFSET))
                           : (r_q.cur + ADDR_W'({r_q.idx, 2'b00}));
        mem_wdata = d_ctrl_ret;
        mv_start  = (r_q.st == ST_MOVE);
        mv_addr   = desc.buf_addr;
        mv_len    = desc.size;
        busy      = (r_q.st != ST_IDLE);
        chain_done = r_q.done;
        own_err   = r_q.err;
        irq       = r_q.irq;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4
    wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[BIT_OWN]);

    // R2
    mv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);

    // R3
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> (mv_len != '0));

    // R5
    err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_err) |-> (irq && !busy));

    // R6
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chain_done && own_err));

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: tb/sg_chain_walker_bench.sv
module sg_chain_walker_bench;
    typedef logic [63:0] q64_t[$];

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [63:0] head_addr;
    logic        busy, chain_done, own_err, irq;
    logic        mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mv_start, mv_done;
    logic [63:0] mv_addr;
    logic [31:0] mv_len;

    always #2 clk = ~clk;

    sg_chain_walker u_sg_chain_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr),
        .busy(busy), .chain_done(chain_done), .own_err(own_err), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_start(mv_start), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done)
    );

    int total = 0;
    int fails = 0;

    logic [31:0] mem_img [logic [63:0]];
    q64_t rd_log, wa_log, wd_log, sa_log, sl_log;
    int irq_cycles;
    int hold_viol;
    int mem_wait;
    logic pend;
    logic [63:0] p_addr;
    logic p_we;
    int mv_cnt;

    // memory responder
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            pend      <= 1'b0;
            mem_wait  <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (irq) irq_cycles++;
            if (mem_req && !mem_ack) begin
                if (pend && (mem_addr != p_addr || mem_we != p_we)) hold_viol++;
                pend   <= 1'b1;
                p_addr <= mem_addr;
                p_we   <= mem_we;
                if (mem_wait == 0) begin
                    mem_ack <= 1'b1;
                    pend    <= 1'b0;
                    if (mem_we) begin
                        mem_img[mem_addr] = mem_wdata;
                        wa_log.push_back(mem_addr);
                        wd_log.push_back(64'(mem_wdata));
                    end else begin
                        mem_rdata <= mem_img.exists(mem_addr) ? mem_img[mem_addr] : 32'h0;
                        rd_log.push_back(mem_addr);
                    end
                    mem_wait <= int'($urandom_range(0, 2));
                end else begin
                    mem_wait <= mem_wait - 1;
                end
            end
        end
    end

    // data mover model
    always @(posedge clk) begin
        if (!rst_n) begin
            mv_done <= 1'b0;
            mv_cnt  <= 0;
        end else begin
            mv_done <= 1'b0;
            if (mv_start) begin
                sa_log.push_back(mv_addr);
                sl_log.push_back(64'(mv_len));
                mv_cnt <= int'($urandom_range(1, 4));
            end else if (mv_cnt > 0) begin
                mv_cnt <= mv_cnt - 1;
                if (mv_cnt == 1) mv_done <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cmp_q(input string req, input string what, input q64_t act, input q64_t exp);
        int bad = -1;
        if (act.size() != exp.size()) begin
            chk(0, req, {what, " count"}, 64'(act.size()), 64'(exp.size()));
            return;
        end
        for (int k = 0; k < act.size(); k++) begin
            if (bad < 0 && act[k] !== exp[k]) bad = k;
        end
        if (bad >= 0) chk(0, req, what, act[bad], exp[bad]);
        else chk(1, req, what, 0, 0);
    endtask

    // bench-side chain image
    logic [63:0] d_addr [8];
    logic [63:0] d_buf  [8];
    logic [63:0] d_nxt  [8];
    logic [31:0] d_size [8];
    logic [31:0] d_ctrl [8];
    int run_id = 0;

    q64_t e_rd, e_wa, e_wd, e_sa, e_sl;
    int e_irq;
    bit e_done, e_err;

    task automatic build_chain(input int n, input int end_mode, input int err_at,
                               input int mid_end_at, input int zero_at);
        run_id++;
        for (int i = 0; i < n; i++) begin
            d_addr[i] = {32'($urandom) | 32'h1, 16'($urandom), 8'(run_id), 3'(i), 5'h0};
        end
        for (int i = 0; i < n; i++) begin
            d_buf[i]  = {32'($urandom), 32'($urandom)};
            d_size[i] = ($urandom_range(0, 3) == 0 || i == zero_at) ? 32'h0
                        : 32'($urandom_range(1, 4096));
            d_ctrl[i] = {1'b1, 29'($urandom), 1'($urandom), 1'b0};
            d_nxt[i]  = (i < n - 1) ? d_addr[i + 1] : {32'($urandom) | 32'h1, 32'h40};
            if (i == n - 1) begin
                if (end_mode == 0 || end_mode == 2) d_ctrl[i][0] = 1'b1;
                if (end_mode == 1 || end_mode == 2) d_nxt[i] = '0;
            end
            if (i == mid_end_at) d_ctrl[i][0] = 1'b1;
            if (i == err_at) d_ctrl[i][31] = 1'b0;
            mem_img[d_addr[i] + 64'd0]  = d_buf[i][31:0];
            mem_img[d_addr[i] + 64'd4]  = d_buf[i][63:32];
            mem_img[d_addr[i] + 64'd8]  = d_size[i];
            mem_img[d_addr[i] + 64'd12] = d_ctrl[i];
            mem_img[d_addr[i] + 64'd16] = d_nxt[i][31:0];
            mem_img[d_addr[i] + 64'd20] = d_nxt[i][63:32];
        end
    endtask

    task automatic expect_walk();
        int i = 0;
        e_rd = {}; e_wa = {}; e_wd = {}; e_sa = {}; e_sl = {};
        e_irq = 0; e_done = 0; e_err = 0;
        forever begin
            for (int w = 0; w < 6; w++) e_rd.push_back(d_addr[i] + 64'(4 * w));
            if (!d_ctrl[i][31]) begin
                e_err = 1; e_irq++;
                break;
            end
            if (d_size[i] != 0) begin
                e_sa.push_back(d_buf[i]);
                e_sl.push_back(64'(d_size[i]));
            end
            e_wa.push_back(d_addr[i] + 64'd12);
            e_wd.push_back(64'(d_ctrl[i] & 32'h7fff_ffff));
            if (d_ctrl[i][1]) e_irq++;
            if (d_ctrl[i][0] || d_nxt[i] == 0) begin
                e_done = 1;
                break;
            end
            i++;
        end
    endtask

    task automatic run_chain(input string tag, input int restart_after);
        int n = 0;
        rd_log = {}; wa_log = {}; wd_log = {}; sa_log = {}; sl_log = {};
        irq_cycles = 0;
        hold_viol = 0;
        expect_walk();
        @(negedge clk);
        head_addr = d_addr[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: accepted start clears sticky status
        chk(busy && !chain_done && !own_err, "R9", {tag, " status cleared on start"},
            {61'b0, busy, chain_done, own_err}, 64'h4);
        if (restart_after > 0) begin
            repeat (restart_after) @(negedge clk);
            head_addr = {32'hdead_0001, 32'h0000_0100};
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(!busy, "R2", {tag, " walk finished"}, 64'(busy), 64'h0);
        cmp_q("R1", {tag, " descriptor read addresses"}, rd_log, e_rd);
        cmp_q("R2", {tag, " segment addresses"}, sa_log, e_sa);
        cmp_q("R3", {tag, " segment lengths (zero skipped)"}, sl_log, e_sl);
        cmp_q("R4", {tag, " write-back addresses"}, wa_log, e_wa);
        cmp_q("R4", {tag, " write-back words"}, wd_log, e_wd);
        chk(irq_cycles == e_irq, "R8", {tag, " irq cycles"}, 64'(irq_cycles), 64'(e_irq));
        chk(chain_done == e_done, "R6", {tag, " chain_done (R7)"}, 64'(chain_done), 64'(e_done));
        chk(own_err == e_err, "R5", {tag, " own_err"}, 64'(own_err), 64'(e_err));
        chk(hold_viol == 0, "R10", {tag, " request held stable"}, 64'(hold_viol), 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0417));
        rst_n = 1'b0;
        start = 1'b0;
        head_addr = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !chain_done && !own_err && !irq && !mem_req && !mv_start,
            "R9", "reset state idle",
            {58'b0, busy, chain_done, own_err, irq, mem_req, mv_start}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R6: single zero-size descriptor ending on the flag, live next pointer
        build_chain(1, 0, -1, -1, 0);
        d_ctrl[0][1] = 1'b1;
        mem_img[d_addr[0] + 64'd12] = d_ctrl[0];
        run_chain("single-zero", 0);

        // R7: three descriptors, last ends only on null next
        build_chain(3, 1, -1, -1, -1);
        run_chain("null-next", 0);

        // R5: ownership error on the second descriptor
        build_chain(4, 0, 1, -1, -1);
        run_chain("own-error", 0);

        // R9: new run clears the error; start while busy is ignored
        build_chain(4, 2, -1, -1, -1);
        run_chain("restart-busy", 3);

        // R6: end flag in the middle of a longer linked list
        build_chain(5, 1, -1, 2, -1);
        run_chain("mid-end", 0);

        for (int t = 0; t < 14; t++) begin
            int n    = int'($urandom_range(1, 6));
            int em   = int'($urandom_range(0, 2));
            int ea   = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, n - 1)) : -1;
            int me   = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, n - 1)) : -1;
            build_chain(n, em, ea, me, -1);
            run_chain($sformatf("rand%0d", t), 0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule